// File: doc/BRIEF.md
# Early-Terminating Iterative Multiply-Accumulate Unit

This block is a sequential 32-bit integer multiplier for a processor datapath. After a start strobe it forms the low 32 bits of `multiplicand × multiplier`. When `acc_en` is set it also adds `addend`. It retires two multiplier bits per clock using radix-4 Booth recoding. The digit set is {-2, -1, 0, +1, +2} times the multiplicand, and the partial sum starts from the addend (accumulate) or from zero (multiply only).

The unit stops as soon as the multiplier bits it has not yet used, together with the pending Booth carry, are all zero. Latency therefore depends only on the magnitude of the multiplier, treated as unsigned, and runs from 1 to 16 cycles. Each finished operation reports its cycle count, the result and N/Z flags together with a one-cycle completion pulse.

Top module: `iter_mac`

## Requirements
- R1: With `acc_en` low, the result equals the low 32 bits of `multiplicand × multiplier`.
- R2: With `acc_en` high, the result equals the low 32 bits of `multiplicand × multiplier + addend`. The cycle rule is the same as for the plain multiply.
- R3: A multiplier of 0 or 1 takes exactly 1 cycle, and `cycle_count` reads 1.
- R4: For 2 ≤ m ≤ 15, a multiplier in the range 2^(2m-3) to 2^(2m-1)-1 takes exactly m cycles, and `cycle_count` reads m.
- R5: A multiplier of 2^29 or more, read as unsigned, takes 16 cycles. No operation takes more than 16 cycles.
- R6: `busy` rises on the clock edge that samples `start` while idle. `done` is a single-cycle pulse that appears m edges later, and on that same edge `busy` falls.
- R7: A `start` seen while `busy` is high is ignored. The running operation finishes with its own operands and latency, and no extra completion follows.
- R8: Results are correct modulo 2^32 for operands that are negative in two's complement.
- R9: `neg_flag` equals bit 31 of the result, and `zero_flag` is high exactly when the result is zero.
- R10: Between completion pulses, `result`, the flags and `cycle_count` hold their values. After reset they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (only acted on when idle) |
| acc_en | input | 1 | Add `addend` to the product |
| multiplicand | input | 32 | Operand multiplied |
| multiplier | input | 32 | Operand whose magnitude sets latency |
| addend | input | 32 | Accumulate operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Low 32 bits of the result |
| neg_flag | output | 1 | Result bit 31 |
| zero_flag | output | 1 | Result is zero |
| cycle_count | output | 5 | Iterations used by the last operation |

## Verification
The edge that samples `start` is edge k. The result, flags, cycle count and `done` pulse are all due after edge k+m, where m comes from the range rule. The bench computes m from the multiplier alone and records the due cycle against a free-running edge counter. The monitor samples on falling edges and compares the edge counter against that due value, so a result that comes one cycle early or late is reported even when its value is right. An intruding start during a long operation must produce neither a changed result nor a second completion.

// File: rtl/iter_mac.sv
module iter_mac #(
  parameter int W     = 32,
  parameter int STEPS = W / 2,
  parameter int CW    = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          acc_en,
  input  logic [W-1:0]  multiplicand,
  input  logic [W-1:0]  multiplier,
  input  logic [W-1:0]  addend,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  result,
  output logic          neg_flag,
  output logic          zero_flag,
  output logic [CW-1:0] cycle_count
);

  logic [W-1:0]  acc, mcand, rest, term, acc_nxt, rest_nxt;
  logic          carry, carry_nxt, last;
  logic [CW-1:0] steps;

  always_comb begin
    case ({rest[1:0], carry})
      3'b001, 3'b010: term = mcand;
      3'b011:         term = mcand << 1;
      3'b100:         term = -(mcand << 1);
      3'b101, 3'b110: term = -mcand;
      default:        term = '0;
    endcase
  end

  assign acc_nxt   = acc + term;
  assign rest_nxt  = rest >> 2;
  assign carry_nxt = rest[1];
  assign last      = (rest_nxt == '0 && !carry_nxt) || steps == CW'(STEPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      acc         <= '0;
      mcand       <= '0;
      rest        <= '0;
      carry       <= 1'b0;
      steps       <= '0;
      result      <= '0;
      neg_flag    <= 1'b0;
      zero_flag   <= 1'b0;
      cycle_count <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          acc   <= acc_en ? addend : '0;
          mcand <= multiplicand;
          rest  <= multiplier;
          carry <= 1'b0;
          steps <= '0;
        end
      end else begin
        acc   <= acc_nxt;
        mcand <= mcand << 2;
        rest  <= rest_nxt;
        carry <= carry_nxt;
        steps <= steps + 1'b1;
        if (last) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          result      <= acc_nxt;
          neg_flag    <= acc_nxt[W-1];
          zero_flag   <= (acc_nxt == '0);
          cycle_count <= steps + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R6
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R6
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (busy || done) && steps == $past(steps) + 1'b1); // R7
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) busy |-> steps < CW'(STEPS)); // R5
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cycle_count >= 1 && cycle_count <= CW'(STEPS))); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(result) && $stable(cycle_count))); // R10
  AST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) done |-> !(neg_flag && zero_flag)); // R9

endmodule

// File: tb/iter_mac_tb.sv
`timescale 1ns/1ps
module iter_mac_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, acc_en = 1'b0;
  logic [31:0] mcand = '0, mplier = '0, addend = '0;
  logic busy, done, neg_flag, zero_flag;
  logic [31:0] result;
  logic [4:0] cycle_count;

  iter_mac u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_en(acc_en),
    .multiplicand(mcand), .multiplier(mplier), .addend(addend),
    .busy(busy), .done(done), .result(result), .neg_flag(neg_flag),
    .zero_flag(zero_flag), .cycle_count(cycle_count)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] q_res[$];
  int q_m[$], q_due[$];
  string q_tag[$];
  logic [31:0] last_res = '0;
  int last_m = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic [31:0] v);
    if (v < 2) return 1;
    for (int m = 2; m < 16; m++)
      if (64'(v) >= (64'd1 << (2*m-3)) && 64'(v) <= (64'd1 << (2*m-1)) - 1) return m;
    return 16;
  endfunction

  function automatic string lat_tag(input logic [31:0] v);
    if (v < 2) return "R3";
    if (v >= 32'h2000_0000) return "R5";
    return "R4";
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input bit acc, input string tag,
                       input bit intrude);
    int m;
    @(negedge clk);
    while (busy) @(negedge clk);
    m = exp_cycles(b);
    q_res.push_back(a * b + (acc ? c : 32'd0));
    q_m.push_back(m);
    q_due.push_back(cyc + 1 + m);
    q_tag.push_back(tag);
    start = 1'b1; mcand = a; mplier = b; addend = c; acc_en = acc;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      start = 1'b1; mcand = 32'h1234_5678; mplier = 32'd3; addend = 32'd99; acc_en = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_res.size() == 0) begin
        chk(1'b0, "R7", "unexpected completion", result, last_res);
      end else begin
        logic [31:0] er;
        int em, ed;
        string tg;
        er = q_res.pop_front(); em = q_m.pop_front();
        ed = q_due.pop_front(); tg = q_tag.pop_front();
        chk(result == er, tg, "result", result, er);
        chk(cycle_count == 5'(em), lat_tag(32'(em) == 32'd1 ? 32'd0 : (em == 16 ? 32'hFFFF_FFFF : 32'd2)),
            "cycle_count", 32'(cycle_count), 32'(em));
        chk(cyc == ed, "R6", "done cycle", 32'(cyc), 32'(ed));
        chk(!busy, "R6", "busy at done", 32'(busy), 32'd0);
        chk(neg_flag == er[31] && zero_flag == (er == 0), "R9", "flags",
            {30'd0, neg_flag, zero_flag}, {30'd0, er[31], er == 0});
        last_res = er; last_m = em;
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R10", "reset busy/done", {30'd0, busy, done}, 32'd0);
    chk(result == 0 && cycle_count == 0 && !neg_flag && !zero_flag, "R10",
        "reset result", result, 32'd0);
    rst_n = 1'b1;

    issue(32'd7, 32'd0, 32'd0, 1'b0, "R1", 1'b0);
    issue(32'd7, 32'd1, 32'd0, 1'b0, "R1", 1'b0);
    issue(32'd0, 32'd5, 32'd0, 1'b0, "R1", 1'b0);
    for (int m = 2; m < 16; m++) begin
      issue(32'h0001_0003, 32'd1 << (2*m-3), 32'd0, 1'b0, "R1", 1'b0);
      issue(32'h0000_0101, (32'd1 << (2*m-1)) - 1, 32'd0, 1'b0, "R1", 1'b0);
    end
    issue(32'd3, 32'h2000_0000, 32'd0, 1'b0, "R1", 1'b0);
    issue(32'd9, 32'hFFFF_FFFF, 32'd0, 1'b0, "R8", 1'b0);
    issue(32'd9, 32'h8000_0000, 32'd0, 1'b0, "R1", 1'b0);
    issue(32'd100, 32'd200, 32'd55, 1'b1, "R2", 1'b0);
    issue(32'hFFFF_FFFF, 32'd1, 32'd1, 1'b1, "R2", 1'b0);
    issue(32'hDEAD_BEEF, 32'hCAFE_0001, 32'h1111_2222, 1'b1, "R2", 1'b0);
    issue(-32'sd7, 32'd3, 32'd0, 1'b0, "R8", 1'b0);
    issue(-32'sd5, -32'sd9, 32'd0, 1'b0, "R8", 1'b0);
    issue(32'd6, -32'sd6, 32'd36, 1'b1, "R8", 1'b0);
    issue(32'h0004_0000, 32'h0000_4000, 32'd0, 1'b0, "R9", 1'b0);
    issue(32'd77, 32'hF000_0001, 32'd5, 1'b1, "R7", 1'b1);
    repeat (25) @(negedge clk);
    chk(result == last_res && cycle_count == 5'(last_m), "R10", "hold after R7 run",
        result, last_res);
    for (int i = 0; i < 150; i++) begin
      logic [31:0] b;
      b = $urandom >> ($urandom % 32);
      issue($urandom, b, $urandom, 1'($urandom), i[0] ? "R2" : "R1", 1'b0);
    end
    @(negedge clk);
    while (busy || q_res.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(result == last_res && !done, "R10", "idle hold", result, last_res);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule